// File: doc/BRIEF.md
# Byte Serial Peripheral Controller with Sequenced Status Flags

This block is a byte-wide SPI peripheral that a processor drives through a small synchronous register bus. It has three registers: a control register, a read-only status register and a data register. It can act as bus master, generating SCK from the system clock, or as a slave clocked by an external master. Every transfer moves eight bits, MSB first, in both directions at once.

Three status flags report on the link: transfer complete, write collision and mode fault. None of them is cleared by writing a one. Each clears only after a two-step access sequence, and the first step is a status read taken while the flag is set. That read arms a per-flag latch, and the latch stays armed across unrelated register accesses.

Received bytes land in a separate receive buffer, so software reads a stable value while the shift register is reloaded. A mode fault (select pulled low while acting as master) drops the block out of master mode and aborts any byte in flight. The interrupt request is a level signal.

Top module: `spi_stat_ctrl`

## Requirements
- R1: After reset, status (address 1) reads 0x00, control (address 0) reads 0x00, irq is 0 and sck_o is 0.
- R2: With control bits enable (bit 1) and master (bit 2) set and ss_n_i high, a write to data (address 2) shifts the byte out on mosi_o MSB first, one bit per sck_o period of 2*HALF_DIV clocks. mosi_o changes on the falling edge of sck_o and miso_i is sampled on the rising edge. When the eighth bit finishes, status bit 7 sets and the received byte appears at data.
- R3: Status bit 7 clears only after a status read taken while it is 1, followed later by a data read or write. A data access with no such status read before it leaves the bit set.
- R4: While status bit 7 is 1, a data write is ignored. It starts no transfer and does not change what the next transfer sends. This includes the data write that completes the clearing sequence.
- R5: A data write made while a byte is being shifted sets status bit 6 (write collision) and is discarded, so the byte in flight continues unchanged. Bit 6 clears after a status read taken while it is 1, followed by a data access.
- R6: A control-register access between the arming status read and the data access does not disarm the clearing sequence.
- R7: In master mode with enable set, ss_n_i low sets status bit 4 (mode fault) and clears control bit 2. Bit 4 clears only after a status read taken while it is 1, followed by a control write. A control write with no such status read before it leaves bit 4 set.
- R8: A mode fault aborts any transfer in flight. sck_o returns to 0, and the aborted byte never sets status bit 7.
- R9: irq equals control bit 0 (interrupt enable) ANDed with the OR of status bits 7 and 4. It stays asserted until those flags are cleared.
- R10: With enable set, master clear and ss_n_i low, the block shifts as a slave. On each rising edge of sck_i it samples mosi_i. miso_o presents the loaded byte MSB first and advances on each falling edge of sck_i. After eight bits, status bit 7 sets.
- R11: A data read returns the receive buffer, which is updated only when a transfer completes. Loading a new byte into the shift register does not change what a data read returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| bus_rd | input | 1 | Read strobe, one clock per access |
| bus_wr | input | 1 | Write strobe, one clock per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| irq | output | 1 | Level interrupt request |
| sck_o | output | 1 | Serial clock generated in master mode |
| mosi_o | output | 1 | Serial data out in master mode |
| miso_i | input | 1 | Serial data in for master mode |
| sck_i | input | 1 | Serial clock in for slave mode |
| mosi_i | input | 1 | Serial data in for slave mode |
| miso_o | output | 1 | Serial data out for slave mode |
| ss_n_i | input | 1 | Active-low slave select, also the mode-fault sense in master mode |

## Verification
The master path is swept over all 256 transmit bytes, each paired with an arithmetically derived receive byte. A dropped bit, a reversed bit order or a sample taken on the wrong edge therefore shows up in either the captured mosi_o stream or the buffered receive byte. Sixteen slave transfers use unrelated byte pairs in each direction, which separates the mosi_i sampling path from the miso_o output path. The flag sequences are driven in orders that distinguish the armed case from the unarmed one: a data access with no status read before it, an intervening control access, a write while complete, a write while shifting, and a control write before and after the arming read. An edge counter on sck_o shows whether an ignored write started anything.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_STAT = 2'd1,
        REG_DATA = 2'd2
    } reg_sel_e;

    // control register bit positions
    localparam int CTRL_IEN  = 0;
    localparam int CTRL_EN   = 1;
    localparam int CTRL_MSTR = 2;
    localparam int CTRL_W    = 3;

    // flag indices inside the flag bank
    localparam int FLG_DONE = 0;
    localparam int FLG_WCOL = 1;
    localparam int FLG_MODF = 2;
    localparam int FLG_N    = 3;

    function automatic logic [BYTE_W-1:0] pack_status(input logic [FLG_N-1:0] f);
        return {f[FLG_DONE], f[FLG_WCOL], 1'b0, f[FLG_MODF], 4'b0000};
    endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int N = 3,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d_i,
    output logic [N-1:0] q_o
);
    logic [N-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= RST_VAL;
            q_o    <= RST_VAL;
        end else begin
            meta_q <= d_i;
            q_o    <= meta_q;
        end
    end
endmodule

// File: rtl/spi_flag_bank.sv
module spi_flag_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic         arm_ev_i,
    input  logic [N-1:0] clr_ev_i,
    output logic [N-1:0] flag_o
);
    logic [N-1:0] armed_q;

    for (genvar g = 0; g < N; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                flag_o[g]  <= 1'b0;
                armed_q[g] <= 1'b0;
            end else begin
                if (arm_ev_i && flag_o[g])
                    armed_q[g] <= 1'b1;
                if (clr_ev_i[g] && armed_q[g]) begin
                    flag_o[g]  <= 1'b0;
                    armed_q[g] <= 1'b0;
                end
                if (set_i[g])
                    flag_o[g] <= 1'b1;
            end
        end

        // R3 R5 R7: a flag falls only when its clearing access arrives
        flag_fall_chk: assert property (@(posedge clk) disable iff (rst)
            $fell(flag_o[g]) |-> $past(clr_ev_i[g]));
    end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
    parameter int W        = 8,
    parameter int HALF_DIV = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         enable_i,
    input  logic         master_i,
    input  logic         abort_i,
    input  logic         load_i,
    input  logic [W-1:0] load_data_i,
    input  logic         miso_i,
    input  logic         sck_s_i,
    input  logic         ss_s_i,
    input  logic         mosi_s_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] rx_o,
    output logic         sck_o,
    output logic         mosi_o,
    output logic         miso_o
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST_BIT = CW'(W - 1);
    localparam logic [DW-1:0] DIV_END  = DW'(HALF_DIV - 1);

    logic [W-1:0]  sr_q;
    logic [CW-1:0] cnt_q;
    logic [DW-1:0] div_q;
    logic          sck_q, smp_q, act_q, sck_prev_q;
    logic          slv_sel, slv_rise, slv_fall;

    assign slv_sel  = enable_i && !master_i && !ss_s_i;
    assign slv_rise = sck_s_i && !sck_prev_q;
    assign slv_fall = !sck_s_i && sck_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0; cnt_q <= '0; div_q <= '0; rx_o <= '0;
            sck_q <= 1'b0; smp_q <= 1'b0; act_q <= 1'b0;
            sck_prev_q <= 1'b0; done_o <= 1'b0;
        end else begin
            done_o     <= 1'b0;
            sck_prev_q <= sck_s_i;
            if (abort_i) begin
                act_q <= 1'b0; sck_q <= 1'b0; cnt_q <= '0; div_q <= '0;
            end else if (load_i) begin
                sr_q <= load_data_i;
                if (master_i && enable_i) begin
                    act_q <= 1'b1; cnt_q <= '0; div_q <= '0; sck_q <= 1'b0;
                end
            end else if (master_i) begin
                if (act_q) begin
                    if (div_q == DIV_END) begin
                        div_q <= '0;
                        sck_q <= !sck_q;
                        if (!sck_q) begin
                            smp_q <= miso_i;
                        end else begin
                            sr_q <= {sr_q[W-2:0], smp_q};
                            if (cnt_q == LAST_BIT) begin
                                act_q  <= 1'b0;
                                done_o <= 1'b1;
                                rx_o   <= {sr_q[W-2:0], smp_q};
                                cnt_q  <= '0;
                            end else begin
                                cnt_q <= cnt_q + 1'b1;
                            end
                        end
                    end else begin
                        div_q <= div_q + 1'b1;
                    end
                end
            end else if (slv_sel) begin
                if (slv_rise) begin
                    smp_q <= mosi_s_i;
                    act_q <= 1'b1;
                end else if (slv_fall && act_q) begin
                    sr_q <= {sr_q[W-2:0], smp_q};
                    if (cnt_q == LAST_BIT) begin
                        act_q  <= 1'b0;
                        done_o <= 1'b1;
                        rx_o   <= {sr_q[W-2:0], smp_q};
                        cnt_q  <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            end else begin
                act_q <= 1'b0;
                cnt_q <= '0;
            end
        end
    end

    assign busy_o = act_q;
    assign sck_o  = sck_q;
    assign mosi_o = sr_q[W-1];
    assign miso_o = slv_sel ? sr_q[W-1] : 1'b0;

    // R2: completion only ends an active transfer
    done_from_active_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(act_q));

    // R8: an abort leaves the serial clock low
    abort_sck_low_chk: assert property (@(posedge clk) disable iff (rst)
        $past(abort_i) |-> !sck_q && !act_q);
endmodule

// File: rtl/spi_stat_ctrl.sv
module spi_stat_ctrl
    import spi_stat_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              irq,
    output logic              sck_o,
    output logic              mosi_o,
    input  logic              miso_i,
    input  logic              sck_i,
    input  logic              mosi_i,
    output logic              miso_o,
    input  logic              ss_n_i
);
    logic [CTRL_W-1:0] ctrl_q;
    logic [FLG_N-1:0]  flags, flag_set, flag_clr;
    logic [2:0]        sync_q;
    logic              sck_s, ss_s, mosi_s;
    logic              sel_ctrl, sel_stat, sel_data;
    logic              data_wr, data_acc, stat_rd, ctrl_wr;
    logic              busy, done_pulse, load, modf_set;
    logic [BYTE_W-1:0] rx_buf;

    spi_sync #(.N(3), .RST_VAL(3'b010)) u_sync (
        .clk(clk), .rst(rst),
        .d_i({sck_i, ss_n_i, mosi_i}), .q_o(sync_q)
    );
    assign {sck_s, ss_s, mosi_s} = sync_q;

    assign sel_ctrl = (bus_addr == REG_CTRL);
    assign sel_stat = (bus_addr == REG_STAT);
    assign sel_data = (bus_addr == REG_DATA);
    assign data_wr  = bus_wr && sel_data;
    assign data_acc = (bus_rd || bus_wr) && sel_data;
    assign stat_rd  = bus_rd && sel_stat;
    assign ctrl_wr  = bus_wr && sel_ctrl;

    assign load     = data_wr && !flags[FLG_DONE] && !busy;
    assign modf_set = ctrl_q[CTRL_EN] && ctrl_q[CTRL_MSTR] && !ss_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else begin
            if (ctrl_wr)
                ctrl_q <= bus_wdata[CTRL_W-1:0];
            if (modf_set)
                ctrl_q[CTRL_MSTR] <= 1'b0;
        end
    end

    spi_shift_engine #(.W(BYTE_W), .HALF_DIV(HALF_DIV)) u_engine (
        .clk(clk), .rst(rst),
        .enable_i(ctrl_q[CTRL_EN]), .master_i(ctrl_q[CTRL_MSTR]),
        .abort_i(modf_set), .load_i(load), .load_data_i(bus_wdata),
        .miso_i(miso_i), .sck_s_i(sck_s), .ss_s_i(ss_s), .mosi_s_i(mosi_s),
        .busy_o(busy), .done_o(done_pulse), .rx_o(rx_buf),
        .sck_o(sck_o), .mosi_o(mosi_o), .miso_o(miso_o)
    );

    always_comb begin
        flag_set           = '0;
        flag_set[FLG_DONE] = done_pulse;
        flag_set[FLG_WCOL] = data_wr && !flags[FLG_DONE] && busy;
        flag_set[FLG_MODF] = modf_set;
        flag_clr           = '0;
        flag_clr[FLG_DONE] = data_acc;
        flag_clr[FLG_WCOL] = data_acc;
        flag_clr[FLG_MODF] = ctrl_wr;
    end

    spi_flag_bank #(.N(FLG_N)) u_flags (
        .clk(clk), .rst(rst), .set_i(flag_set), .arm_ev_i(stat_rd),
        .clr_ev_i(flag_clr), .flag_o(flags)
    );

    always_comb begin
        case (bus_addr)
            REG_CTRL: bus_rdata = {{(BYTE_W-CTRL_W){1'b0}}, ctrl_q};
            REG_STAT: bus_rdata = pack_status(flags);
            REG_DATA: bus_rdata = rx_buf;
            default:  bus_rdata = '0;
        endcase
    end

    assign irq = ctrl_q[CTRL_IEN] && (flags[FLG_DONE] || flags[FLG_MODF]);

    // R4
    write_while_done_chk: assert property (@(posedge clk) disable iff (rst)
        (flags[FLG_DONE] && data_wr && ctrl_q[CTRL_MSTR] && !busy) |=> !busy);

    // R5
    wcol_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[FLG_WCOL]) |-> $past(bus_wr && bus_addr == REG_DATA && busy));

    // R7
    modf_drops_master_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[FLG_MODF]) |-> !ctrl_q[CTRL_MSTR] && !sck_o);

    // R2
    done_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[FLG_DONE]) |-> $past(done_pulse));
endmodule

// File: tb/test_spi_stat_ctrl.sv
module test_spi_stat_ctrl;
    logic       clk = 1'b0, rst = 1'b1;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00, bus_rdata;
    logic       irq, sck_o, mosi_o, miso_o;
    logic       miso_i = 1'b0, sck_i = 1'b0, mosi_i = 1'b0, ss_n_i = 1'b1;

    int   vectors = 0, errs = 0, sck_edges = 0;
    bit   finished = 0;
    logic [7:0] mosi_cap = 8'h00, slv_sr = 8'h00;

    always #10 clk = !clk;

    spi_stat_ctrl #(.HALF_DIV(2)) i_spi_stat_ctrl (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .sck_o(sck_o),
        .mosi_o(mosi_o), .miso_i(miso_i), .sck_i(sck_i), .mosi_i(mosi_i),
        .miso_o(miso_o), .ss_n_i(ss_n_i)
    );

    // bench model of an external slave for master-mode transfers
    always @(posedge sck_o) begin
        mosi_cap = {mosi_cap[6:0], mosi_o};
        sck_edges++;
    end
    always @(negedge sck_o) begin
        slv_sr = {slv_sr[6:0], 1'b0};
        miso_i = slv_sr[7];
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        vectors++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic master_xfer(input logic [7:0] tx, input logic [7:0] pat, output logic [7:0] rx);
        logic [7:0] st;
        slv_sr = pat; miso_i = pat[7];
        wr_reg(2'd2, tx);
        st = 8'h00;
        for (int k = 0; k < 100 && st[7] == 1'b0; k++) rd_reg(2'd1, st);
        rd_reg(2'd2, rx);
    endtask

    task automatic slave_xfer(input logic [7:0] mo, output logic [7:0] mi);
        ss_n_i = 1'b0;
        for (int b = 7; b >= 0; b--) begin
            mosi_i = mo[b];
            wait_clks(6);
            mi[b] = miso_o;
            sck_i = 1'b1;
            wait_clks(6);
            sck_i = 1'b0;
        end
        wait_clks(6);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errs++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
            $finish;
        end
    end

    initial begin
        logic [7:0] d, rx, pat, stx, mo, mi;
        int e0;
        wait_clks(5);
        rst = 1'b0;
        wait_clks(2);

        // R1 reset state
        rd_reg(2'd1, d); chk(d, 8'h00, "R1 status");
        rd_reg(2'd0, d); chk(d, 8'h00, "R1 control");
        chk(irq, 1'b0, "R1 irq");
        chk(sck_o, 1'b0, "R1 sck");

        // R2 exhaustive master sweep, interrupt disabled (R9 gating)
        wr_reg(2'd0, 8'h06);
        for (int t = 0; t < 256; t++) begin
            pat = 8'(t * 37 + 11);
            master_xfer(8'(t), pat, rx);
            chk(mosi_cap, t, "R2 mosi stream");
            chk(rx, pat, "R2 received byte");
            rd_reg(2'd1, d); chk(d, 8'h00, "R3 cleared after sequence");
        end

        // R3 unarmed data access keeps flag; R6 control access keeps arm
        slv_sr = 8'hA5; miso_i = 1'b1;
        wr_reg(2'd2, 8'h3C);
        wait_clks(60);
        chk(irq, 1'b0, "R9 irq gated off");
        rd_reg(2'd2, d); chk(d, 8'hA5, "R11 buffer holds rx");
        rd_reg(2'd1, d); chk(d, 8'h80, "R3 unarmed data read keeps flag");
        rd_reg(2'd0, d);
        rd_reg(2'd2, d);
        rd_reg(2'd1, d); chk(d, 8'h00, "R6 arm survives control access");

        // R4 writes ignored while complete
        slv_sr = 8'h5A; miso_i = 1'b0;
        wr_reg(2'd2, 8'hC3);
        wait_clks(60);
        e0 = sck_edges;
        wr_reg(2'd2, 8'h11);
        wait_clks(60);
        chk(sck_edges, e0, "R4 unarmed write starts nothing");
        rd_reg(2'd1, d); chk(d, 8'h80, "R4 no collision while complete");
        wr_reg(2'd2, 8'h22);
        wait_clks(60);
        chk(sck_edges, e0, "R4 clearing write starts nothing");
        rd_reg(2'd1, d); chk(d, 8'h00, "R4 clearing write clears flag");
        rd_reg(2'd2, d); chk(d, 8'h5A, "R11 buffer unchanged");

        // R5 write collision
        slv_sr = 8'h96; miso_i = 1'b1;
        wr_reg(2'd2, 8'h81);
        wait_clks(4);
        wr_reg(2'd2, 8'h7E);
        wait_clks(60);
        chk(mosi_cap, 8'h81, "R5 byte in flight unchanged");
        rd_reg(2'd1, d); chk(d, 8'hC0, "R5 collision flag");
        rd_reg(2'd2, d); chk(d, 8'h96, "R5 received byte");
        rd_reg(2'd1, d); chk(d, 8'h00, "R5 both flags cleared");

        // R9 interrupt level
        wr_reg(2'd0, 8'h07);
        master_xfer(8'h44, 8'h99, rx);
        chk(irq, 1'b0, "R9 irq low after clear");
        slv_sr = 8'h00; miso_i = 1'b0;
        wr_reg(2'd2, 8'h55);
        wait_clks(60);
        chk(irq, 1'b1, "R9 irq on complete");
        wait_clks(10);
        chk(irq, 1'b1, "R9 irq level held");
        rd_reg(2'd1, d); rd_reg(2'd2, d);
        chk(irq, 1'b0, "R9 irq dropped");

        // R7 R8 mode fault during a transfer
        e0 = sck_edges;
        wr_reg(2'd2, 8'hF0);
        wait_clks(3);
        ss_n_i = 1'b0;
        wait_clks(4);
        chk(sck_o, 1'b0, "R8 sck released");
        rd_reg(2'd0, d); chk(d, 8'h03, "R7 master bit cleared");
        chk(irq, 1'b1, "R9 irq on mode fault");
        e0 = sck_edges;
        wait_clks(60);
        chk(sck_edges, e0, "R8 transfer aborted");
        wr_reg(2'd0, 8'h03);
        rd_reg(2'd1, d); chk(d, 8'h10, "R7 unarmed control write keeps fault, R8 no completion");
        wr_reg(2'd0, 8'h01);
        rd_reg(2'd1, d); chk(d, 8'h00, "R7 fault cleared");
        chk(irq, 1'b0, "R9 irq dropped after fault");
        ss_n_i = 1'b1;

        // R10 slave transfers
        wr_reg(2'd0, 8'h02);
        wait_clks(4);
        for (int k = 0; k < 16; k++) begin
            stx = 8'(k * 29 + 3);
            mo  = 8'(k * 53 + 1);
            wr_reg(2'd2, stx);
            slave_xfer(mo, mi);
            chk(mi, stx, "R10 miso stream");
            rd_reg(2'd1, d); chk(d, 8'h80, "R10 completion flag");
            rd_reg(2'd2, d); chk(d, mo, "R10 received byte");
            ss_n_i = 1'b1;
            wait_clks(4);
        end

        // R11 loading the shift register leaves the buffer alone
        wr_reg(2'd2, 8'hEE);
        rd_reg(2'd2, d); chk(d, 8'(15 * 53 + 1), "R11 buffer after load");
        rd_reg(2'd1, d); chk(d, 8'h00, "R11 no flags after load");

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end
endmodule